// File: doc/BRIEF.md
# Sprite Row Offset Counter

This block tracks, for one sprite of a raster video controller, which three-byte row of a 63-byte sprite image is fetched on each raster line. A sprite image holds 21 rows of three bytes. When the sprite is enabled and its vertical position matches the low eight bits of the current raster line at a line end, the block starts fetching. It then presents the byte offset of the first of the three data fetches for each line. The other two fetches use the next two offsets. Separate flags show when fetching is active and when the fetched rows are being shown.

The counter holding the row base is cleared only after a display has ended, never when one begins. Its value at power-up is a parameter. A base of 0 gives a normal 21-line image. A base of 63 makes the first display after power-on wrap through the 64-byte offset space before it reaches the end value, so it runs for 64 lines. Other starting values that are multiples of three give shorter or longer first displays. The system reset input never touches the counters: it only holds off new displays, and a display already running completes as usual.

Top module: `sprRowCounter`

## Requirements
- R1: After power-on, before any line end, dmaOn and dispOn are low and mcOut equals the INIT_BASE parameter (63 by default).
- R2: On a lineEnd pulse with spriteEn high, sysReset low, no display active, and spriteY equal to rasterLine modulo 256, dmaOn goes high on the next clock and mcOut shows the row base.
- R3: On each lineEnd pulse while dmaOn is high and the row is not held, mcOut advances by 3 modulo 64.
- R4: dmaOn and dispOn fall together on the lineEnd pulse at which the row base reaches 63. Measured in line ends after the start, a display lasts 21 from base 0, 20 from base 3 and 64 from base 63.
- R5: The row base is cleared to 0 only after a display ends, so the next display starts with mcOut equal to 0 and lasts 21 lines.
- R6: A line end with vExpand high makes the following line repeat the current row. While vExpand stays high on every line, mcOut holds its value and the display does not end.
- R7: While sysReset is high no display starts, but a display already active keeps advancing and ends normally.
- R8: dispOn rises on the first line end after dmaOn rises, and is never high while dmaOn is low.
- R9: In any cycle without a lineEnd pulse, mcOut, dmaOn and dispOn keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sysReset | input | 1 | System reset; blocks new starts only |
| lineEnd | input | 1 | One-cycle pulse at the end of each raster line |
| spriteEn | input | 1 | Sprite enable |
| vExpand | input | 1 | Vertical expansion / row hold for the next line |
| spriteY | input | Y_W (8) | Sprite vertical position |
| rasterLine | input | RASTER_W (9) | Current raster line |
| mcOut | output | CNT_W (6) | Byte offset of the first data fetch of the line |
| dmaOn | output | 1 | Sprite data fetching active |
| dispOn | output | 1 | Sprite display active |

## Verification
The checks assume that lineEnd is a single-cycle pulse and that two pulses are never on consecutive clocks, so the deferred clear of the row base always lands on a cycle with no line end. They also assume that inputs change only between clock edges. The stimulus steps every line through one task that raises lineEnd for one clock and then drops it for at least one more, and it changes all other inputs on falling edges. Because the counters have no reset, the checker enables itself after the first clock edge instead of waiting on a reset.

// File: rtl/sprRowPkg.sv
package sprRowPkg;
  // Strobes from the control FSM to the row datapath, all valid for one clock.
  typedef struct packed {
    logic load;    // copy the row base into the working offset (display start)
    logic step;    // a line of fetches finished: move the working offset
    logic commit;  // the row base follows the working offset this line
    logic wipe;    // clear the row base (one cycle after display end)
  } rowCtlT;
endpackage

// File: rtl/sprRowDatapath.sv
module sprRowDatapath
  import sprRowPkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int STEP      = 3,
  parameter int INIT_BASE = 63
) (
  input  logic             clk,
  input  rowCtlT           ctl,
  output logic [CNT_W-1:0] mcOut,
  output logic             endHit
);
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);
  localparam logic [CNT_W-1:0] END_V  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] INIT_V = CNT_W'(INIT_BASE);

  // No reset: both counters only get their power-on value.
  logic [CNT_W-1:0] rowBase = INIT_V;
  logic [CNT_W-1:0] workOfs = INIT_V;
  logic [CNT_W-1:0] fetched;
  logic [CNT_W-1:0] nextBase;

  assign fetched  = workOfs + STEP_V;
  assign nextBase = ctl.commit ? fetched : rowBase;
  assign endHit   = (nextBase == END_V);
  assign mcOut    = workOfs;

  always_ff @(posedge clk) begin
    if (ctl.wipe)
      rowBase <= '0;
    else if (ctl.commit)
      rowBase <= fetched;
  end

  always_ff @(posedge clk) begin
    if (ctl.load)
      workOfs <= rowBase;
    else if (ctl.step)
      workOfs <= nextBase;
  end
endmodule

// File: rtl/sprRowControl.sv
module sprRowControl
  import sprRowPkg::*;
#(
  parameter int RASTER_W = 9,
  parameter int Y_W      = 8
) (
  input  logic                clk,
  input  logic                sysReset,
  input  logic                lineEnd,
  input  logic                spriteEn,
  input  logic                vExpand,
  input  logic [Y_W-1:0]      spriteY,
  input  logic [RASTER_W-1:0] rasterLine,
  input  logic                endHit,
  output rowCtlT              ctl,
  output logic                dmaOn,
  output logic                dispOn
);
  localparam logic [RASTER_W-1:0] Y_MASK = RASTER_W'((1 << Y_W) - 1);

  logic dmaQ      = 1'b0;
  logic dispQ     = 1'b0;
  logic advanceFf = 1'b1;  // set: the row base follows on the next line end
  logic wipePend  = 1'b0;

  logic yMatch, startReq, stepReq, finish;

  assign yMatch   = (rasterLine & Y_MASK) == RASTER_W'(spriteY);
  assign startReq = lineEnd && !dmaQ && spriteEn && yMatch && !sysReset;
  assign stepReq  = lineEnd && dmaQ;
  assign finish   = stepReq && endHit;

  always_comb begin
    ctl.load   = startReq;
    ctl.step   = stepReq;
    ctl.commit = stepReq && advanceFf;
    ctl.wipe   = wipePend;
  end

  always_ff @(posedge clk) begin
    wipePend <= finish;
    if (startReq) begin
      dmaQ      <= 1'b1;
      advanceFf <= 1'b1;
    end else if (stepReq) begin
      advanceFf <= ~vExpand;
      if (finish) begin
        dmaQ  <= 1'b0;
        dispQ <= 1'b0;
      end else begin
        dispQ <= 1'b1;
      end
    end
  end

  assign dmaOn  = dmaQ;
  assign dispOn = dispQ;
endmodule

// File: rtl/sprRowCounter.sv
module sprRowCounter
  import sprRowPkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int STEP      = 3,
  parameter int INIT_BASE = 63,
  parameter int RASTER_W  = 9,
  parameter int Y_W       = 8
) (
  input  logic                clk,
  input  logic                sysReset,
  input  logic                lineEnd,
  input  logic                spriteEn,
  input  logic                vExpand,
  input  logic [Y_W-1:0]      spriteY,
  input  logic [RASTER_W-1:0] rasterLine,
  output logic [CNT_W-1:0]    mcOut,
  output logic                dmaOn,
  output logic                dispOn
);
  rowCtlT ctl;
  logic   endHit;

  sprRowControl #(.RASTER_W(RASTER_W), .Y_W(Y_W)) u_ctrl (
    .clk(clk), .sysReset(sysReset), .lineEnd(lineEnd), .spriteEn(spriteEn),
    .vExpand(vExpand), .spriteY(spriteY), .rasterLine(rasterLine),
    .endHit(endHit), .ctl(ctl), .dmaOn(dmaOn), .dispOn(dispOn)
  );

  sprRowDatapath #(.CNT_W(CNT_W), .STEP(STEP), .INIT_BASE(INIT_BASE)) u_data (
    .clk(clk), .ctl(ctl), .mcOut(mcOut), .endHit(endHit)
  );
endmodule

// File: rtl/sprRowCounterChecker.sv
module sprRowCounterChecker #(
  parameter int CNT_W = 6,
  parameter int STEP  = 3
) (
  input logic             clk,
  input logic             sysReset,
  input logic             lineEnd,
  input logic             spriteEn,
  input logic [CNT_W-1:0] mcOut,
  input logic             dmaOn,
  input logic             dispOn
);
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

  // The counters have no reset; checking starts after the first edge.
  logic live = 1'b0;
  always_ff @(posedge clk) live <= 1'b1;

  p_quiet_r9: assert property (@(posedge clk) disable iff (!live)
    !lineEnd |=> ($stable(mcOut) && $stable(dmaOn) && $stable(dispOn)));

  p_step_r3: assert property (@(posedge clk) disable iff (!live)
    (lineEnd && dmaOn) |=> (mcOut == $past(mcOut) + STEP_V || mcOut == $past(mcOut)));

  p_disp_needs_dma_r8: assert property (@(posedge clk) disable iff (!live)
    dispOn |-> dmaOn);

  p_disp_rise_r8: assert property (@(posedge clk) disable iff (!live)
    $rose(dispOn) |-> $past(dmaOn && lineEnd));

  p_start_gate_r7: assert property (@(posedge clk) disable iff (!live)
    $rose(dmaOn) |-> $past(lineEnd && spriteEn && !sysReset));

  p_end_r4: assert property (@(posedge clk) disable iff (!live)
    $fell(dmaOn) |-> (!dispOn && $past(lineEnd)));
endmodule

bind sprRowCounter sprRowCounterChecker #(.CNT_W(CNT_W), .STEP(STEP)) u_chk (
  .clk(clk), .sysReset(sysReset), .lineEnd(lineEnd), .spriteEn(spriteEn),
  .mcOut(mcOut), .dmaOn(dmaOn), .dispOn(dispOn)
);

// File: tb/sprRowCounter_test.sv
module sprRowCounter_test;
  logic       clk = 1'b0;
  logic       sysReset = 1'b0;
  logic       lineEnd = 1'b0;
  logic       vExpand = 1'b0;
  logic [2:0] enVec = 3'b000;
  logic [7:0] spriteY = 8'h00;
  logic [8:0] rasterLine = 9'h1FF;
  logic [5:0] mcO [3];
  logic       dmaO [3];
  logic       dispO [3];

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  // index 0: base 0, index 1: base 63 (default), index 2: base 3
  sprRowCounter #(.INIT_BASE(0)) uutZero (
    .clk(clk), .sysReset(sysReset), .lineEnd(lineEnd), .spriteEn(enVec[0]),
    .vExpand(vExpand), .spriteY(spriteY), .rasterLine(rasterLine),
    .mcOut(mcO[0]), .dmaOn(dmaO[0]), .dispOn(dispO[0]));

  sprRowCounter uut (
    .clk(clk), .sysReset(sysReset), .lineEnd(lineEnd), .spriteEn(enVec[1]),
    .vExpand(vExpand), .spriteY(spriteY), .rasterLine(rasterLine),
    .mcOut(mcO[1]), .dmaOn(dmaO[1]), .dispOn(dispO[1]));

  sprRowCounter #(.INIT_BASE(3)) uutThree (
    .clk(clk), .sysReset(sysReset), .lineEnd(lineEnd), .spriteEn(enVec[2]),
    .vExpand(vExpand), .spriteY(spriteY), .rasterLine(rasterLine),
    .mcOut(mcO[2]), .dmaOn(dmaO[2]), .dispOn(dispO[2]));

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One line end: pulse high for one clock, then low; sample after the edge.
  task automatic strobe();
    @(negedge clk) lineEnd = 1'b1;
    @(negedge clk) lineEnd = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  // Start a display on one instance and follow it to its end.
  task automatic runDisplay(input int idx, input int initV, input int expLines);
    int exp;
    spriteY = 8'h40; rasterLine = 9'h040; enVec[idx] = 1'b1;
    strobe();
    enVec[idx] = 1'b0; rasterLine = 9'h041;
    chk("R2 start dmaOn", int'(dmaO[idx]), 1);
    chk("R2 start offset", int'(mcO[idx]), initV);
    chk("R8 dispOn waits a line", int'(dispO[idx]), 0);
    exp = initV;
    for (int k = 1; k <= expLines; k++) begin
      strobe();
      exp = (exp + 3) % 64;
      chk("R3 offset step", int'(mcO[idx]), exp);
      if (k < expLines) begin
        chk("R4 still active", int'(dmaO[idx]), 1);
        chk("R8 dispOn during display", int'(dispO[idx]), 1);
      end else begin
        chk("R4 dmaOn ends", int'(dmaO[idx]), 0);
        chk("R4 dispOn ends", int'(dispO[idx]), 0);
      end
    end
  endtask

  task automatic testPowerUp();
    #1;
    chk("R1 dmaOn base0", int'(dmaO[0]), 0);
    chk("R1 dispOn base0", int'(dispO[0]), 0);
    chk("R1 offset base0", int'(mcO[0]), 0);
    chk("R1 offset base63", int'(mcO[1]), 63);
    chk("R1 dmaOn base63", int'(dmaO[1]), 0);
    chk("R1 offset base3", int'(mcO[2]), 3);
  endtask

  task automatic testNoStart();
    spriteY = 8'h20;
    enVec[0] = 1'b1; rasterLine = 9'h021;
    strobe();
    chk("R2 no start on Y mismatch", int'(dmaO[0]), 0);
    enVec[0] = 1'b0; rasterLine = 9'h020;
    strobe();
    chk("R2 no start when disabled", int'(dmaO[0]), 0);
    enVec[0] = 1'b1; sysReset = 1'b1;
    strobe();
    chk("R7 no start in reset", int'(dmaO[0]), 0);
    sysReset = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 no start without line end", int'(dmaO[0]), 0);
    chk("R9 offset steady", int'(mcO[0]), 0);
    enVec[0] = 1'b0; rasterLine = 9'h1FF;
  endtask

  task automatic testNormal();
    runDisplay(0, 0, 21);
    runDisplay(0, 0, 21);  // R5: base cleared, same length again
  endtask

  task automatic testOverrun();
    runDisplay(1, 63, 64);
    runDisplay(1, 0, 21);  // R5: overrun happens once only
  endtask

  task automatic testShort();
    runDisplay(2, 3, 20);
  endtask

  task automatic testHoldAndReset();
    int exp;
    spriteY = 8'h0A; rasterLine = 9'h10A; enVec[0] = 1'b1;
    strobe();
    enVec[0] = 1'b0; rasterLine = 9'h10B;
    chk("R2 match uses low raster bits", int'(dmaO[0]), 1);
    chk("R5 start after clear", int'(mcO[0]), 0);
    vExpand = 1'b1;
    strobe();
    chk("R6 first line still advances", int'(mcO[0]), 3);
    for (int k = 0; k < 3; k++) begin
      strobe();
      chk("R6 row held", int'(mcO[0]), 3);
      chk("R6 display continues", int'(dmaO[0]), 1);
    end
    vExpand = 1'b0;
    strobe();
    chk("R6 hold lasts one more line", int'(mcO[0]), 3);
    strobe();
    chk("R6 advance resumes", int'(mcO[0]), 6);
    sysReset = 1'b1;
    @(negedge clk);
    chk("R7 reset leaves offset", int'(mcO[0]), 6);
    chk("R7 reset leaves dmaOn", int'(dmaO[0]), 1);
    exp = 6;
    while (exp != 63) begin
      strobe();
      exp = exp + 3;
      chk("R7 advances during reset", int'(mcO[0]), exp);
    end
    chk("R7 ends normally in reset", int'(dmaO[0]), 0);
    enVec[0] = 1'b1; rasterLine = 9'h10A;
    strobe();
    chk("R7 no restart in reset", int'(dmaO[0]), 0);
    enVec[0] = 1'b0; sysReset = 1'b0;
  endtask

  initial begin
    testPowerUp();
    testNoStart();
    testNormal();
    testOverrun();
    testShort();
    testHoldAndReset();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule